// File: doc/BRIEF.md
# Converter Front-End Control Register

This block holds the single configuration byte of a small two-input sampling converter front end and turns it into the control levels and requests that the rest of the front end consumes. A host writes and reads the byte over a plain register bus: a write strobe with a data byte, and combinational read data. From the stored byte the block decides whether the shared second analog pin serves as the reference input or as a second signal input. It also drives the enable for the bus-line glitch filter and configures a shared interrupt pin.

The block issues conversion requests on a valid/ready channel, each carrying the channel to sample. It can sample one fixed input, or alternate between the two inputs, always starting on input 1. A request, once raised, holds its channel steady until the converter accepts it. After acceptance no new request is raised until the converter reports completion with a one-cycle done strobe. Back-pressure therefore only stalls the request: the channel is never skipped or changed while it waits, except when the host rewrites the register.

The interrupt pin can stay idle, mirror the converter busy level, or mirror the alert level from the limit logic, with either polarity. Writing the pin-role code 11 is a command rather than a setting. It emits a one-cycle alert-clear pulse and leaves the pin in alert role.

Top module: `adc_ctrl_top`

## Requirements
- R1: After reset the register reads 0x00, no request is raised, alert_clr is low, ref_sel and filt_en are low, and irq_pin is high (idle level for active-low).
- R2: A write stores bits 6:0 of the byte. Bit 7 is ignored and always reads back as 0.
- R3: ref_sel follows bit 6: 1 means the shared pin is the reference input (single-channel use), 0 means it is the second analog input.
- R4: filt_en follows bit 3: 1 enables the bus-line filter, 0 bypasses it.
- R5: Bits 5:4 select the request channel. 00 raises no request, 01 requests channel ID 0 (input 1), and 10 requests channel ID 1 (input 2).
- R6: With bits 5:4 = 11 requests alternate between channel IDs 0 and 1. The first request is ID 0, the ID flips after each done strobe that ends an accepted request, and any register write returns it to ID 0.
- R7: conv_valid stays high with conv_chan stable until conv_ready is seen high on a clock edge. After that handshake conv_valid stays low until conv_done is pulsed.
- R8: Bits 2:1 set the interrupt role. 00 keeps the pin inactive, 01 makes it follow busy_in, and 10 makes it follow alert_in.
- R9: Bit 0 sets the pin polarity for every role. At 0 the active level is low (irq_pin = not signal); at 1 it is high (irq_pin = signal).
- R10: Writing 11 into bits 2:1 drives alert_clr high for exactly the one cycle after the write. The register then holds 10 in bits 2:1, so it reads back with bit 2 = 1 and bit 1 = 0, and the pin acts in alert role.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write byte |
| rd_data | output | 8 | Register read byte |
| conv_valid | output | 1 | Conversion request valid |
| conv_ready | input | 1 | Converter accepts the request |
| conv_chan | output | 1 | Channel ID of the request (0 = input 1) |
| conv_done | input | 1 | One-cycle conversion-complete strobe |
| busy_in | input | 1 | Converter busy level |
| alert_in | input | 1 | Limit alert level |
| ref_sel | output | 1 | Shared pin acts as reference input |
| filt_en | output | 1 | Bus-line filter enable |
| alert_clr | output | 1 | One-cycle alert clear pulse |
| irq_pin | output | 1 | Shared ALERT/BUSY pin level |

## Verification
The assertions assume that conv_done arrives only for a request already accepted, and that a host does not rewrite the register to stop a pending request it wants kept. The request-hold property is therefore qualified by the absence of a write. The random phase keeps conv_ready and conv_done low so that register writes never race a handshake. The directed phase drives ready and done one cycle apart, in the order a converter would. busy_in and alert_in are free random levels, since the pin logic places no constraint on them.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
  localparam int REG_W  = 8;
  localparam int CFG_W  = 7;
  localparam int CHAN_W = 1;

  typedef enum logic [1:0] {
    CH_OFF = 2'b00,
    CH_IN1 = 2'b01,
    CH_IN2 = 2'b10,
    CH_ALT = 2'b11
  } chan_mode_e;

  typedef enum logic [1:0] {
    ROLE_NONE  = 2'b00,
    ROLE_BUSY  = 2'b01,
    ROLE_ALERT = 2'b10,
    ROLE_CLEAR = 2'b11
  } pin_role_e;

  typedef struct packed {
    logic       ref_mode;
    chan_mode_e chan;
    logic       filt;
    pin_role_e  role;
    logic       pol;
  } ctrl_t;
endpackage

// File: rtl/adc_ctrl_cfg.sv
module adc_ctrl_cfg
  import adc_ctrl_pkg::*;
#(
  parameter int DATA_W = REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output ctrl_t             cfg,
  output logic              clr_pulse
);
  ctrl_t nxt;

  always_comb begin
    nxt = ctrl_t'(wr_data[CFG_W-1:0]);
    // the clear code is a command: keep the alert role, drop the command bit
    if (nxt.role == ROLE_CLEAR) nxt.role = ROLE_ALERT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg       <= '0;
      clr_pulse <= 1'b0;
    end else begin
      clr_pulse <= wr_en && (wr_data[2:1] == 2'b11);
      if (wr_en) cfg <= nxt;
    end
  end
endmodule

// File: rtl/adc_ctrl_seq.sv
module adc_ctrl_seq
  import adc_ctrl_pkg::*;
#(
  parameter int ID_W = CHAN_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  chan_mode_e      mode,
  input  logic            restart,
  input  logic            req_ready,
  input  logic            done,
  output logic            req_valid,
  output logic [ID_W-1:0] req_chan
);
  logic            waiting;
  logic [ID_W-1:0] ptr;

  assign req_valid = (mode != CH_OFF) && !waiting;

  always_comb begin
    unique case (mode)
      CH_IN1:  req_chan = ID_W'(0);
      CH_IN2:  req_chan = ID_W'(1);
      CH_ALT:  req_chan = ptr;
      default: req_chan = ID_W'(0);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      waiting <= 1'b0;
      ptr     <= '0;
    end else begin
      if (req_valid && req_ready) waiting <= 1'b1;
      else if (done && waiting)   waiting <= 1'b0;

      if (restart)
        ptr <= '0;
      else if (done && waiting && mode == CH_ALT)
        ptr <= ptr ^ ID_W'(1);
    end
  end
endmodule

// File: rtl/adc_ctrl_irq.sv
module adc_ctrl_irq
  import adc_ctrl_pkg::*;
(
  input  pin_role_e role,
  input  logic      pol,
  input  logic      busy_in,
  input  logic      alert_in,
  output logic      pin
);
  logic sel;

  always_comb begin
    unique case (role)
      ROLE_BUSY:  sel = busy_in;
      ROLE_ALERT: sel = alert_in;
      default:    sel = 1'b0;
    endcase
  end

  assign pin = sel ^ ~pol;
endmodule

// File: rtl/adc_ctrl_top.sv
module adc_ctrl_top
  import adc_ctrl_pkg::*;
#(
  parameter int DATA_W = REG_W,
  parameter int ID_W   = CHAN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              conv_valid,
  input  logic              conv_ready,
  output logic [ID_W-1:0]   conv_chan,
  input  logic              conv_done,
  input  logic              busy_in,
  input  logic              alert_in,
  output logic              ref_sel,
  output logic              filt_en,
  output logic              alert_clr,
  output logic              irq_pin
);
  ctrl_t cfg;

  adc_ctrl_cfg #(.DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .cfg(cfg), .clr_pulse(alert_clr)
  );

  adc_ctrl_seq #(.ID_W(ID_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .mode(cfg.chan), .restart(wr_en),
    .req_ready(conv_ready), .done(conv_done),
    .req_valid(conv_valid), .req_chan(conv_chan)
  );

  adc_ctrl_irq u_irq (
    .role(cfg.role), .pol(cfg.pol), .busy_in(busy_in),
    .alert_in(alert_in), .pin(irq_pin)
  );

  assign rd_data = {{(DATA_W-CFG_W){1'b0}}, cfg};
  assign ref_sel = cfg.ref_mode;
  assign filt_en = cfg.filt;
endmodule

// File: rtl/adc_ctrl_chk.sv
module adc_ctrl_chk #(
  parameter int DATA_W = 8,
  parameter int ID_W   = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              conv_valid,
  input logic              conv_ready,
  input logic [ID_W-1:0]   conv_chan,
  input logic              alert_clr,
  input logic              irq_pin
);
  assert_clr_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    alert_clr |-> ($past(wr_en) && $past(wr_data[2:1]) == 2'b11));

  assert_rd_role_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[2] |-> !rd_data[1]);

  assert_rd_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[DATA_W-1]);

  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_valid && !conv_ready && !wr_en) |=> (conv_valid && $stable(conv_chan)));

  assert_req_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_valid && conv_ready && !wr_en) |=> !conv_valid);

  assert_no_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[5:4] == 2'b00) |-> !conv_valid);

  assert_idle_pin_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[2:1] == 2'b00) |-> (irq_pin == !rd_data[0]));
endmodule

bind adc_ctrl_top adc_ctrl_chk #(.DATA_W(DATA_W), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .conv_valid(conv_valid), .conv_ready(conv_ready),
  .conv_chan(conv_chan), .alert_clr(alert_clr), .irq_pin(irq_pin)
);

// File: tb/test_adc_ctrl_top.sv
`timescale 1ns/1ps
module test_adc_ctrl_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       conv_valid, conv_ready = 1'b0, conv_done = 1'b0;
  logic [0:0] conv_chan;
  logic       busy_in = 1'b0, alert_in = 1'b0;
  logic       ref_sel, filt_en, alert_clr, irq_pin;

  int checks = 0, failures = 0;
  bit finished = 0;

  logic [6:0] m_reg;
  bit         m_wait;
  bit         m_ptr;

  always #2 clk = ~clk;

  adc_ctrl_top i_adc_ctrl_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .conv_valid(conv_valid), .conv_ready(conv_ready),
    .conv_chan(conv_chan), .conv_done(conv_done), .busy_in(busy_in),
    .alert_in(alert_in), .ref_sel(ref_sel), .filt_en(filt_en),
    .alert_clr(alert_clr), .irq_pin(irq_pin)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] exp_store(logic [7:0] d);
    logic [6:0] r = d[6:0];
    if (r[2:1] == 2'b11) r[2:1] = 2'b10;
    return r;
  endfunction

  function automatic logic exp_pin(logic [6:0] r, logic b, logic a);
    logic s;
    case (r[2:1])
      2'b01:   s = b;
      2'b10:   s = a;
      default: s = 1'b0;
    endcase
    return r[0] ? s : !s;
  endfunction

  function automatic logic exp_chan(logic [6:0] r, bit p);
    case (r[5:4])
      2'b10:   return 1'b1;
      2'b11:   return p;
      default: return 1'b0;
    endcase
  endfunction

  task automatic write(logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
    m_reg = exp_store(d); m_ptr = 0;
    #1;
  endtask

  task automatic accept();
    @(negedge clk); conv_ready = 1'b1;
    @(negedge clk); conv_ready = 1'b0; m_wait = 1;
    #1;
  endtask

  task automatic finish_conv();
    @(negedge clk); conv_done = 1'b1;
    @(negedge clk); conv_done = 1'b0;
    if (m_wait && m_reg[5:4] == 2'b11) m_ptr = !m_ptr;
    m_wait = 0;
    #1;
  endtask

  initial begin
    #400000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    m_reg = '0; m_wait = 0; m_ptr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 rd_data", rd_data, 8'h00);
    check("R1 conv_valid", conv_valid, 0);
    check("R1 alert_clr", alert_clr, 0);
    check("R1 ref_sel", ref_sel, 0);
    check("R1 filt_en", filt_en, 0);
    check("R1 irq_pin", irq_pin, 1);

    // R5 fixed channels
    write(8'h10);
    check("R5 valid in1", conv_valid, 1);
    check("R5 chan in1", conv_chan, 0);
    write(8'h20);
    check("R5 valid in2", conv_valid, 1);
    check("R5 chan in2", conv_chan, 1);

    // R6 / R7 alternating sequence with back-pressure
    write(8'h30);
    check("R6 first id", conv_chan, 0);
    repeat (4) @(negedge clk);
    #1;
    check("R7 held valid", conv_valid, 1);
    check("R7 held chan", conv_chan, 0);
    accept();
    check("R7 gap after accept", conv_valid, 0);
    @(negedge clk); #1;
    check("R7 still gap", conv_valid, 0);
    finish_conv();
    check("R7 valid after done", conv_valid, 1);
    check("R6 second id", conv_chan, 1);
    accept(); finish_conv();
    check("R6 third id", conv_chan, 0);
    accept(); finish_conv();
    check("R6 fourth id", conv_chan, 1);
    write(8'h30);
    check("R6 write restarts", conv_chan, 0);
    accept();
    write(8'h30);
    check("R7 write keeps wait", conv_valid, 0);
    finish_conv();
    check("R6 id after restart", conv_chan, 1);
    write(8'h00);
    check("R5 off no request", conv_valid, 0);

    // R10 clear command
    write(8'h87);
    check("R10 readback", rd_data, 8'h05);
    check("R10 pulse", alert_clr, 1);
    @(negedge clk); #1;
    check("R10 pulse ends", alert_clr, 0);
    alert_in = 1'b1; #1;
    check("R10 alert role", irq_pin, 1);

    // random register and pin mapping
    for (int i = 0; i < 300; i++) begin
      logic [7:0] d = 8'($urandom);
      write(d);
      check("R2 readback", rd_data, {1'b0, m_reg});
      check("R10 clr pulse", alert_clr, d[2:1] == 2'b11);
      check("R3 ref_sel", ref_sel, m_reg[6]);
      check("R4 filt_en", filt_en, m_reg[3]);
      for (int k = 0; k < 2; k++) begin
        busy_in = 1'($urandom); alert_in = 1'($urandom); #1;
        check("R8 R9 irq_pin", irq_pin, exp_pin(m_reg, busy_in, alert_in));
      end
      check("R5 valid", conv_valid, (m_reg[5:4] != 0) && !m_wait);
      if (conv_valid) check("R5 R6 chan", conv_chan, exp_chan(m_reg, m_ptr));
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule